// File: doc/BRIEF.md
# Privilege-Filtered Cycle and Retire Counters

This block keeps two 64-bit event counters for a hart: one that advances on clock cycles and one that advances when an instruction retires. Each counter has its own filter register holding one inhibit bit per privilege mode. A set bit stops the matching counter whenever the hart is in that mode. The block is fed the current privilege mode and virtualization state every cycle. From the commit stage it takes a per-cycle retire strobe together with the retire mode, an exception flag, a trap-return flag and the mode the trap-return left.

Both filter registers and both counters are reached through a single-cycle CSR port with a 12-bit address and 64-bit data. Each register also has a mirror address for its upper 32 bits, for use on 32-bit harts. Mode changes take effect on the cycle the mode input changes, and that rule never varies. Filter bits of modes the hart lacks are tied to zero through parameters, as are the overflow position and the reserved low field.

Top module: `priv_filt_counters`

## Requirements
- R1: After reset both counters and both filter registers read zero, so nothing is inhibited.
- R2: Bit 63 of each filter register (cycle filter at 0x321, retire filter at 0x322) reads zero and ignores writes.
- R3: Filter bits 57:0 and the inhibit bits of modes not enabled by parameter read zero and ignore writes. With default parameters the virtual-supervisor (bit 59) and virtual-user (bit 58) bits are absent, so modes with the virtualization input set are never inhibited.
- R4: The cycle counter advances by one on a clock edge exactly when the inhibit bit of the current mode is clear. The mode-to-bit mapping is: machine (priv 3) bit 62, supervisor (priv 1) bit 61, user (priv 0) bit 60, virtual supervisor bit 59, virtual user bit 58.
- R5: An ordinary retiring instruction advances the retire counter by one exactly when the inhibit bit of its retire mode is clear.
- R6: A retiring instruction flagged as raising an exception never advances the retire counter, whatever the filter settings.
- R7: A trap-return instruction is filtered by the inhibit bit of its originating mode, not the mode it returns into.
- R8: During a mode change, each cycle counts against the mode presented on the mode input in that cycle.
- R9: A CSR write to a counter takes priority over its increment in the same cycle; the written value appears after the edge.
- R10: Addresses 0x721 and 0x722 read bits 63:32 of the cycle and retire filter registers in data bits 31:0. Writes there change only bits 63:32, subject to R2 and R3.
- R11: The counters are read and written at 0xB00 (cycle) and 0xB02 (retire), with upper halves at 0xB80 and 0xB82. A carry out of bit 31 propagates into the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege mode (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Current virtualization state |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_priv_i | input | 2 | Mode in which the instruction retires |
| ret_virt_i | input | 1 | Virtualization state at retire |
| ret_exc_i | input | 1 | Retiring instruction raised an exception |
| ret_xret_i | input | 1 | Retiring instruction is a trap-return |
| ret_orig_priv_i | input | 2 | Mode a trap-return leaves |
| ret_orig_virt_i | input | 1 | Virtualization state a trap-return leaves |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data for csr_addr_i, zero if unmapped |
| cycle_o | output | 64 | Cycle counter value |
| instret_o | output | 64 | Retire counter value |

## Verification
A wrong filter register shows up one edge later as a counter that holds when it should advance, or advances when it should hold. A wrong mode selection for trap-returns shows only on the retire counter, and only on the edge after that retire. Stuck or writable read-only bits appear at once on the CSR read data, with no clock edge needed. A counter state error persists in cycle_o or instret_o until the next write, so a single delta measurement around one edge exposes it.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned AW = 12;
  localparam int unsigned NCH = 2;  // 0: cycle, 1: retire

  localparam int unsigned BIT_OVF = 63;
  localparam int unsigned BIT_M   = 62;
  localparam int unsigned BIT_S   = 61;
  localparam int unsigned BIT_U   = 60;
  localparam int unsigned BIT_VS  = 59;
  localparam int unsigned BIT_VU  = 58;

  localparam logic [AW-1:0] CFG_LO_ADDR [NCH] = '{12'h321, 12'h322};
  localparam logic [AW-1:0] CFG_HI_ADDR [NCH] = '{12'h721, 12'h722};
  localparam logic [AW-1:0] CNT_LO_ADDR [NCH] = '{12'hB00, 12'hB02};
  localparam logic [AW-1:0] CNT_HI_ADDR [NCH] = '{12'hB80, 12'hB82};

  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_R = 2'd2,
    PRV_M = 2'd3
  } prv_e;

  function automatic logic [DW-1:0] cfg_wmask(input bit has_s, input bit has_u,
                                               input bit has_h);
    logic [DW-1:0] m;
    m = '0;
    m[BIT_M]  = 1'b1;
    m[BIT_S]  = has_s;
    m[BIT_U]  = has_u;
    m[BIT_VS] = has_h & has_s;
    m[BIT_VU] = has_h & has_u;
    return m;
  endfunction
endpackage

// File: rtl/pfc_cfg_reg.sv
module pfc_cfg_reg
  import pfc_pkg::*;
#(
  parameter logic [DW-1:0] WMASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_lo_i)      cfg_d = wdata_i & WMASK;
    else if (we_hi_i) cfg_d = {wdata_i[HW-1:0], cfg_q[HW-1:0]} & WMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pfc_inh_sel.sv
module pfc_inh_sel
  import pfc_pkg::*;
(
  input  logic [4:0] inh_i,   // {M, S, U, VS, VU}
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  output logic       inh_o
);
  prv_e prv;
  assign prv = prv_e'(priv_i);

  always_comb begin
    unique case (prv)
      PRV_M:   inh_o = inh_i[4];
      PRV_S:   inh_o = virt_i ? inh_i[1] : inh_i[3];
      PRV_U:   inh_o = virt_i ? inh_i[0] : inh_i[2];
      default: inh_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfc_counter.sv
module pfc_counter
  import pfc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          inc_i,
  output logic [DW-1:0] cnt_o
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] cnt_q, cnt_d;

  // write wins over increment
  always_comb begin
    if (we_lo_i)      cnt_d = wdata_i;
    else if (we_hi_i) cnt_d = {wdata_i[HW-1:0], cnt_q[HW-1:0]};
    else if (inc_i)   cnt_d = cnt_q + DW'(1);
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/priv_filt_counters.sv
module priv_filt_counters
  import pfc_pkg::*;
#(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_H = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic          ret_valid_i,
  input  logic [1:0]    ret_priv_i,
  input  logic          ret_virt_i,
  input  logic          ret_exc_i,
  input  logic          ret_xret_i,
  input  logic [1:0]    ret_orig_priv_i,
  input  logic          ret_orig_virt_i,
  input  logic          csr_we_i,
  input  logic [AW-1:0] csr_addr_i,
  input  logic [DW-1:0] csr_wdata_i,
  output logic [DW-1:0] csr_rdata_o,
  output logic [DW-1:0] cycle_o,
  output logic [DW-1:0] instret_o
);
  localparam int unsigned HW = DW / 2;
  localparam logic [DW-1:0] WMASK = cfg_wmask(HAS_S, HAS_U, HAS_H);

  logic [DW-1:0] cfg_q   [NCH];
  logic [DW-1:0] cnt_q   [NCH];
  logic [1:0]    ch_priv [NCH];
  logic          ch_virt [NCH];
  logic          ch_en   [NCH];
  logic          ch_inh  [NCH];

  // channel 0 follows the live mode; channel 1 the attributed retire mode
  assign ch_priv[0] = priv_i;
  assign ch_virt[0] = virt_i;
  assign ch_en[0]   = 1'b1;
  assign ch_priv[1] = ret_xret_i ? ret_orig_priv_i : ret_priv_i;
  assign ch_virt[1] = ret_xret_i ? ret_orig_virt_i : ret_virt_i;
  assign ch_en[1]   = ret_valid_i & ~ret_exc_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cfg_we_lo, cfg_we_hi, cnt_we_lo, cnt_we_hi;

    assign cfg_we_lo = csr_we_i && (csr_addr_i == CFG_LO_ADDR[g]);
    assign cfg_we_hi = csr_we_i && (csr_addr_i == CFG_HI_ADDR[g]);
    assign cnt_we_lo = csr_we_i && (csr_addr_i == CNT_LO_ADDR[g]);
    assign cnt_we_hi = csr_we_i && (csr_addr_i == CNT_HI_ADDR[g]);

    pfc_cfg_reg #(.WMASK(WMASK)) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_lo_i (cfg_we_lo),
      .we_hi_i (cfg_we_hi),
      .wdata_i (csr_wdata_i),
      .cfg_o   (cfg_q[g])
    );

    pfc_inh_sel u_sel (
      .inh_i  (cfg_q[g][BIT_M:BIT_VU]),
      .priv_i (ch_priv[g]),
      .virt_i (ch_virt[g]),
      .inh_o  (ch_inh[g])
    );

    pfc_counter u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_lo_i (cnt_we_lo),
      .we_hi_i (cnt_we_hi),
      .wdata_i (csr_wdata_i),
      .inc_i   (ch_en[g] & ~ch_inh[g]),
      .cnt_o   (cnt_q[g])
    );
  end

  always_comb begin
    csr_rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (csr_addr_i == CFG_LO_ADDR[i]) csr_rdata_o = cfg_q[i];
      if (csr_addr_i == CFG_HI_ADDR[i]) csr_rdata_o = {{HW{1'b0}}, cfg_q[i][DW-1:HW]};
      if (csr_addr_i == CNT_LO_ADDR[i]) csr_rdata_o = cnt_q[i];
      if (csr_addr_i == CNT_HI_ADDR[i]) csr_rdata_o = {{HW{1'b0}}, cnt_q[i][DW-1:HW]};
    end
  end

  assign cycle_o   = cnt_q[0];
  assign instret_o = cnt_q[1];

  logic [DW-1:0] cfg_cyc_q, cfg_ret_q, cfg_mask;
  assign cfg_cyc_q = cfg_q[0];
  assign cfg_ret_q = cfg_q[1];
  assign cfg_mask  = WMASK;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
  import pfc_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    priv_i,
  input logic          virt_i,
  input logic          ret_valid_i,
  input logic [1:0]    ret_priv_i,
  input logic          ret_virt_i,
  input logic          ret_exc_i,
  input logic          ret_xret_i,
  input logic [1:0]    ret_orig_priv_i,
  input logic          ret_orig_virt_i,
  input logic          csr_we_i,
  input logic [AW-1:0] csr_addr_i,
  input logic [DW-1:0] csr_wdata_i,
  input logic [DW-1:0] cycle_o,
  input logic [DW-1:0] instret_o,
  input logic [DW-1:0] cfg_cyc_q,
  input logic [DW-1:0] cfg_ret_q,
  input logic [DW-1:0] cfg_mask
);
  function automatic logic blocked(input logic [DW-1:0] c, input logic [1:0] p,
                                   input logic v);
    case (p)
      2'd3:    return c[62];
      2'd1:    return v ? c[59] : c[61];
      2'd0:    return v ? c[58] : c[60];
      default: return 1'b0;
    endcase
  endfunction

  logic wr_cyc, wr_ret;
  assign wr_cyc = csr_we_i && (csr_addr_i == 12'hB00 || csr_addr_i == 12'hB80);
  assign wr_ret = csr_we_i && (csr_addr_i == 12'hB02 || csr_addr_i == 12'hB82);

  assert_ovf_ro_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_cyc_q[63] && !cfg_ret_q[63]);

  assert_unimpl_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_cyc_q & ~cfg_mask) == '0) && ((cfg_ret_q & ~cfg_mask) == '0));

  assert_cyc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cyc && blocked(cfg_cyc_q, priv_i, virt_i)) |=> $stable(cycle_o));

  assert_cyc_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cyc && !blocked(cfg_cyc_q, priv_i, virt_i)) |=> cycle_o == $past(cycle_o) + 64'd1);

  assert_ret_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ret && ret_valid_i && !ret_xret_i && blocked(cfg_ret_q, ret_priv_i, ret_virt_i))
      |=> $stable(instret_o));

  assert_exc_never_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ret && ret_valid_i && ret_exc_i) |=> $stable(instret_o));

  assert_xret_orig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ret && ret_valid_i && !ret_exc_i && ret_xret_i &&
     !blocked(cfg_ret_q, ret_orig_priv_i, ret_orig_virt_i))
      |=> instret_o == $past(instret_o) + 64'd1);

  assert_wr_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == 12'hB00) |=> cycle_o == $past(csr_wdata_i));
endmodule

bind priv_filt_counters pfc_checker u_pfc_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .priv_i          (priv_i),
  .virt_i          (virt_i),
  .ret_valid_i     (ret_valid_i),
  .ret_priv_i      (ret_priv_i),
  .ret_virt_i      (ret_virt_i),
  .ret_exc_i       (ret_exc_i),
  .ret_xret_i      (ret_xret_i),
  .ret_orig_priv_i (ret_orig_priv_i),
  .ret_orig_virt_i (ret_orig_virt_i),
  .csr_we_i        (csr_we_i),
  .csr_addr_i      (csr_addr_i),
  .csr_wdata_i     (csr_wdata_i),
  .cycle_o         (cycle_o),
  .instret_o       (instret_o),
  .cfg_cyc_q       (cfg_cyc_q),
  .cfg_ret_q       (cfg_ret_q),
  .cfg_mask        (cfg_mask)
);

// File: tb/sim_priv_filt_counters.sv
`timescale 1ns/1ps
module sim_priv_filt_counters;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  priv_i = 2'd3;
  logic        virt_i = 1'b0;
  logic        ret_valid_i = 1'b0;
  logic [1:0]  ret_priv_i = 2'd3;
  logic        ret_virt_i = 1'b0;
  logic        ret_exc_i = 1'b0;
  logic        ret_xret_i = 1'b0;
  logic [1:0]  ret_orig_priv_i = 2'd3;
  logic        ret_orig_virt_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [11:0] csr_addr_i = 12'h000;
  logic [63:0] csr_wdata_i = 64'd0;
  logic [63:0] csr_rdata_o, cycle_o, instret_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  priv_filt_counters u0 (.*);

  // {priv, virt, cyc_inh{M,S,U}, ret_inh{M,S,U}, rv, exc, xret, rpriv, opriv, dcyc, dret}
  typedef struct packed {
    logic [1:0] priv;
    logic       virt;
    logic [2:0] cinh;
    logic [2:0] rinh;
    logic       rv;
    logic       exc;
    logic       xret;
    logic [1:0] rpriv;
    logic [1:0] opriv;
    logic       dc;
    logic       dr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 3'b000, 3'b000, 1'b1, 1'b0, 1'b0, 2'd3, 2'd3, 1'b1, 1'b1},  // R4 R5
    '{2'd3, 1'b0, 3'b100, 3'b000, 1'b1, 1'b0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1},  // R4
    '{2'd1, 1'b0, 3'b010, 3'b010, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0},  // R4 R5
    '{2'd0, 1'b0, 3'b010, 3'b010, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1},  // R4 R5
    '{2'd0, 1'b0, 3'b001, 3'b000, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0},  // R6
    '{2'd1, 1'b0, 3'b000, 3'b001, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b1},  // R7
    '{2'd1, 1'b0, 3'b000, 3'b010, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0},  // R7
    '{2'd3, 1'b0, 3'b000, 3'b000, 1'b1, 1'b1, 1'b0, 2'd3, 2'd3, 1'b1, 1'b0},  // R6
    '{2'd0, 1'b0, 3'b110, 3'b110, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1},  // R5
    '{2'd3, 1'b0, 3'b011, 3'b111, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 1'b1, 1'b0},  // R4
    '{2'd0, 1'b1, 3'b001, 3'b001, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1}   // R3
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
    csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
    @(negedge clk_i);
    csr_we_i = 1'b0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [63:0] d);
    csr_addr_i = a;
    #1;
    d = csr_rdata_o;
  endtask

  function automatic logic [63:0] inh_val(input logic [2:0] msu);
    return {1'b0, msu, 60'd0};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] c0, r0, rd;
    @(negedge clk_i);
    // R1: state under reset
    chk("R1 cycle", cycle_o, 64'd0);
    chk("R1 instret", instret_o, 64'd0);
    csr_rd(12'h321, rd); chk("R1 cyc cfg", rd, 64'd0);
    csr_rd(12'h322, rd); chk("R1 ret cfg", rd, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk
    for (int i = 0; i < NV; i++) begin
      csr_wr(12'h321, inh_val(VECS[i].cinh));
      csr_wr(12'h322, inh_val(VECS[i].rinh));
      priv_i = VECS[i].priv; virt_i = VECS[i].virt;
      ret_valid_i = VECS[i].rv; ret_exc_i = VECS[i].exc; ret_xret_i = VECS[i].xret;
      ret_priv_i = VECS[i].rpriv; ret_orig_priv_i = VECS[i].opriv;
      ret_virt_i = VECS[i].virt; ret_orig_virt_i = VECS[i].virt;
      c0 = cycle_o; r0 = instret_o;
      @(negedge clk_i);
      chk($sformatf("R4 vec%0d cycle delta", i), cycle_o - c0, {63'd0, VECS[i].dc});
      chk($sformatf("R5 vec%0d retire delta", i), instret_o - r0, {63'd0, VECS[i].dr});
      ret_valid_i = 1'b0; ret_exc_i = 1'b0; ret_xret_i = 1'b0;
    end

    // R2 R3: read-only positions
    csr_wr(12'h321, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_rd(12'h321, rd); chk("R2 R3 cyc cfg all-ones", rd, 64'h7000_0000_0000_0000);
    csr_wr(12'h322, 64'h8000_0000_0000_0000);
    csr_rd(12'h322, rd); chk("R2 ovf bit ignored", rd, 64'd0);

    // R10: high-half mirror
    csr_rd(12'h721, rd); chk("R10 hi read", rd, 64'h0000_0000_7000_0000);
    csr_wr(12'h722, 64'h0000_0000_2FFF_FFFF);
    csr_rd(12'h322, rd); chk("R10 hi write", rd, 64'h2000_0000_0000_0000);
    csr_wr(12'h321, 64'd0);
    csr_wr(12'h722, 64'h0000_0000_4000_0000);
    csr_rd(12'h322, rd); chk("R10 hi replace", rd, 64'h4000_0000_0000_0000);

    // R8: alternate modes with machine inhibited
    csr_wr(12'h321, inh_val(3'b100));
    priv_i = 2'd3;
    c0 = cycle_o;
    for (int k = 0; k < 4; k++) begin
      priv_i = (k % 2 == 1) ? 2'd1 : 2'd3;
      @(negedge clk_i);
    end
    chk("R8 transition cycles", cycle_o - c0, 64'd2);
    csr_wr(12'h321, 64'd0);

    // R9 R11: counter writes
    csr_wr(12'hB00, 64'd100);
    chk("R9 cycle write wins", cycle_o, 64'd100);
    csr_wr(12'hB80, 64'd5);
    chk("R11 cycle hi write", cycle_o, 64'h0000_0005_0000_0064);
    csr_rd(12'hB80, rd); chk("R11 cycle hi read", rd, 64'd5);
    ret_valid_i = 1'b1; ret_priv_i = 2'd3;
    csr_wr(12'hB02, 64'd7);
    ret_valid_i = 1'b0;
    chk("R9 retire write wins", instret_o, 64'd7);
    csr_rd(12'hB02, rd); chk("R11 retire read", rd, 64'd7);
    csr_wr(12'hB00, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk_i);
    chk("R11 carry into hi", cycle_o, 64'h0000_0001_0000_0000);

    finish_run();
  end
endmodule